// File: doc/BRIEF.md
# Interlocked Link-Training Sub-State Sequencer

This block steers one lane through its training sub-states: two lock phases followed by two training phases, ending in a trained state. In each sub-state it names the ordered set the transmitter should repeat. It also watches the symbols arriving from the link partner. It moves on only when two conditions both hold:
- Enough complete ordered sets of its own have gone out.
- A shorter run of back-to-back matching sets has come in from the far end.

This interlock keeps the two ends of the link in step. If one end meets its transmit quota early, it keeps sending the same set and waits for the far end. If it receives the partner's sets early, it still finishes its own transmit quota before it moves on.

Every wait is bounded by a cycle timeout. On expiry the sequence restarts from the first lock phase and a retry counter steps. After a set number of retries, the next timeout latches a sticky failure flag and parks the sequencer. The enable input models entry into training from any other link state. Dropping the enable returns the block to its off phase. Raising it again starts the full sequence over.

Top module: `ltrain_seq`

## Requirements
- R1: The sequencer leaves a training sub-state only when two counts have both been registered: at least TX_MIN complete sets sent, and a run of at least RX_MIN matching received sets. Either count alone holds the sub-state, and the transmitter keeps repeating the same set.
- R2: The receive run counts valid symbols whose type equals the set of the current sub-state. A valid symbol of any other type resets the run to zero. A cycle with `rx_valid` low neither adds to the run nor breaks it.
- R3: A sent set counts only when `tx_done` is high and `tx_abort` is low in the same cycle. An interrupted set adds nothing.
- R4: Phase codes are OFF=0, LOCK1=1, LOCK2=2, TRN1=3, TRN2=4, DONE=5. Set codes are NONE=0, LOCK_A=1, LOCK_B=2, TRN_A=3, TRN_B=4. LOCK1..TRN2 send and expect codes 1..4 in that order.
- R5: The phase advances on the clock edge that follows the edge at which both counts became met. DONE raises `trained` and sends NONE.
- R6: Both counts and the wait timer clear on every phase change and on every restart. A strobe that arrives in the cycle of the change is dropped.
- R7: A sub-state that lasts TIMEOUT cycles without advancing is left for LOCK1. At the same edge `retry_cnt` increments, and `retry_pulse` is high for that one cycle.
- R8: Once MAX_RETRY retries have been used, the next timeout sets `fail` and moves to OFF. The block then stays in OFF with `fail` high until reset.
- R9: With `train_en` low, the next edge moves the sequencer to OFF from any phase. With `train_en` high and `fail` clear, OFF moves to LOCK1.
- R10: After reset: phase OFF, set NONE, `trained`, `retry_pulse`, `retry_cnt` and `fail` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| train_en | input | 1 | Enter and remain in training |
| rx_valid | input | 1 | A received set is present this cycle |
| rx_set | input | 3 | Type code of the received set |
| tx_done | input | 1 | Strobe: one transmitted set has finished |
| tx_abort | input | 1 | Strobe: the finishing set was interrupted |
| tx_set | output | 3 | Set type to transmit |
| phase | output | 3 | Current sub-state code |
| trained | output | 1 | Sequence complete |
| retry_pulse | output | 1 | One-cycle retry indication |
| retry_cnt | output | $clog2(MAX_RETRY+2) | Retries used since reset |
| fail | output | 1 | Sticky exhaustion flag |

## Verification
The assertions assume that `tx_done` and `tx_abort` are single-cycle strobes, one per finished set. They also assume `rx_set` carries meaning only while `rx_valid` is high, and that `train_en` is a level held for many cycles. The stimulus changes inputs one time unit after each rising edge. It gives at most one receive symbol and one transmit strobe per cycle, and it holds `train_en` steady except in the cycles meant to leave or re-enter training. Received types outside the current sub-state's code are used only to break a run on purpose.

// File: rtl/ltrain_pkg.sv
package ltrain_pkg;

    typedef enum logic [2:0] {
        PH_OFF   = 3'd0,
        PH_LOCK1 = 3'd1,
        PH_LOCK2 = 3'd2,
        PH_TRN1  = 3'd3,
        PH_TRN2  = 3'd4,
        PH_DONE  = 3'd5
    } phase_e;

    typedef enum logic [2:0] {
        SET_NONE   = 3'd0,
        SET_LOCK_A = 3'd1,
        SET_LOCK_B = 3'd2,
        SET_TRN_A  = 3'd3,
        SET_TRN_B  = 3'd4
    } oset_e;

    typedef struct packed {
        logic tx_met;
        logic rx_met;
    } cond_t;

    function automatic oset_e set_of(phase_e p);
        case (p)
            PH_LOCK1: return SET_LOCK_A;
            PH_LOCK2: return SET_LOCK_B;
            PH_TRN1:  return SET_TRN_A;
            PH_TRN2:  return SET_TRN_B;
            default:  return SET_NONE;
        endcase
    endfunction

    function automatic logic is_training(phase_e p);
        return (p == PH_LOCK1) || (p == PH_LOCK2) || (p == PH_TRN1) || (p == PH_TRN2);
    endfunction

    function automatic phase_e phase_after(phase_e p);
        case (p)
            PH_LOCK1: return PH_LOCK2;
            PH_LOCK2: return PH_TRN1;
            PH_TRN1:  return PH_TRN2;
            default:  return PH_DONE;
        endcase
    endfunction

endpackage

// File: rtl/ltrain_cond_cnt.sv
module ltrain_cond_cnt
    import ltrain_pkg::*;
#(
    parameter int TX_MIN = 4,
    parameter int RX_MIN = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  tx_done,
    input  logic  tx_abort,
    input  logic  rx_valid,
    input  logic  rx_match,
    output cond_t cond
);
    localparam int TXW = $clog2(TX_MIN + 1);
    localparam int RXW = $clog2(RX_MIN + 1);
    localparam logic [TXW-1:0] TX_LIM = TXW'(TX_MIN);
    localparam logic [RXW-1:0] RX_LIM = RXW'(RX_MIN);

    logic [TXW-1:0] tx_cnt;
    logic [RXW-1:0] rx_run;
    logic           tx_whole;

    assign tx_whole = tx_done && !tx_abort;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tx_cnt <= '0;
        end else if (tx_whole && (tx_cnt != TX_LIM)) begin
            tx_cnt <= tx_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rx_run <= '0;
        end else if (rx_valid) begin
            if (!rx_match)            rx_run <= '0;
            else if (rx_run != RX_LIM) rx_run <= rx_run + 1'b1;
        end
    end

    assign cond.tx_met = (tx_cnt == TX_LIM);
    assign cond.rx_met = (rx_run == RX_LIM);

    // a foreign symbol leaves no partial run behind
    assert_run_break_R2: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_match && !clr) |=> (rx_run == '0));

    // an interrupted or missing set leaves the sent count untouched
    assert_abort_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (!tx_whole && !clr) |=> $stable(tx_cnt));

endmodule

// File: rtl/ltrain_wait_timer.sv
module ltrain_wait_timer #(
    parameter int TIMEOUT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(TIMEOUT + 1);
    localparam logic [TW-1:0] LIM = TW'(TIMEOUT - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr || !run) begin
            cnt <= '0;
        end else if (cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LIM);

    // expiry always follows a full window of running cycles
    assert_window_R7: assert property (@(posedge clk) disable iff (rst)
        (run && !clr && !expired) |=> (cnt == $past(cnt) + 1'b1) || !run);

endmodule

// File: rtl/ltrain_retry.sv
module ltrain_retry #(
    parameter int MAX_RETRY = 3
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              tmo,
    output logic                              exhausted,
    output logic                              retry_pulse,
    output logic [$clog2(MAX_RETRY+2)-1:0]    retry_cnt,
    output logic                              fail
);
    localparam int RCW = $clog2(MAX_RETRY + 2);
    localparam logic [RCW-1:0] R_LIM = RCW'(MAX_RETRY);

    assign exhausted = (retry_cnt == R_LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            retry_cnt   <= '0;
            retry_pulse <= 1'b0;
            fail        <= 1'b0;
        end else begin
            retry_pulse <= tmo && !exhausted;
            if (tmo) begin
                if (exhausted) fail <= 1'b1;
                else           retry_cnt <= retry_cnt + 1'b1;
            end
        end
    end

    assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        fail |=> fail);

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
        retry_cnt <= R_LIM);

endmodule

// File: rtl/ltrain_seq.sv
module ltrain_seq
    import ltrain_pkg::*;
#(
    parameter int TX_MIN    = 4,
    parameter int RX_MIN    = 2,
    parameter int TIMEOUT   = 1024,
    parameter int MAX_RETRY = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           train_en,
    input  logic                           rx_valid,
    input  logic [2:0]                     rx_set,
    input  logic                           tx_done,
    input  logic                           tx_abort,
    output logic [2:0]                     tx_set,
    output logic [2:0]                     phase,
    output logic                           trained,
    output logic                           retry_pulse,
    output logic [$clog2(MAX_RETRY+2)-1:0] retry_cnt,
    output logic                           fail
);
    phase_e phase_q, phase_d;
    cond_t  cond;
    logic   in_train, adv, tmo, clr, expired, exhausted, rx_match;

    assign in_train = is_training(phase_q);
    assign rx_match = (rx_set == set_of(phase_q));
    assign adv      = train_en && in_train && cond.tx_met && cond.rx_met;
    assign tmo      = train_en && in_train && expired && !adv;

    always_comb begin
        phase_d = phase_q;
        if (!train_en) begin
            phase_d = PH_OFF;
        end else if (phase_q == PH_OFF) begin
            if (!fail) phase_d = PH_LOCK1;
        end else if (adv) begin
            phase_d = phase_after(phase_q);
        end else if (tmo) begin
            phase_d = exhausted ? PH_OFF : PH_LOCK1;
        end
    end

    assign clr = !in_train || tmo || (phase_d != phase_q);

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_OFF;
        else     phase_q <= phase_d;
    end

    ltrain_cond_cnt #(.TX_MIN(TX_MIN), .RX_MIN(RX_MIN)) u_cond (
        .clk(clk), .rst(rst), .clr(clr),
        .tx_done(tx_done), .tx_abort(tx_abort),
        .rx_valid(rx_valid), .rx_match(rx_match),
        .cond(cond)
    );

    ltrain_wait_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk(clk), .rst(rst), .clr(clr), .run(in_train), .expired(expired)
    );

    ltrain_retry #(.MAX_RETRY(MAX_RETRY)) u_retry (
        .clk(clk), .rst(rst), .tmo(tmo), .exhausted(exhausted),
        .retry_pulse(retry_pulse), .retry_cnt(retry_cnt), .fail(fail)
    );

    assign tx_set  = set_of(phase_q);
    assign phase   = phase_q;
    assign trained = (phase_q == PH_DONE);

    // one count alone never moves the phase forward
    assert_hold_single_R1: assert property (@(posedge clk) disable iff (rst)
        (train_en && in_train && !(cond.tx_met && cond.rx_met))
        |=> (phase == $past(phase)) || (phase_q == PH_LOCK1) || (phase_q == PH_OFF));

    // training phases only step forward by one, restart, or leave
    assert_step_order_R4: assert property (@(posedge clk) disable iff (rst)
        (in_train && train_en)
        |=> (phase == $past(phase)) || (phase == $past(phase) + 3'd1)
            || (phase_q == PH_LOCK1) || (phase_q == PH_OFF));

    assert_done_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        trained |-> (tx_set == 3'd0));

    assert_retry_restart_R7: assert property (@(posedge clk) disable iff (rst)
        retry_pulse |-> (phase_q == PH_LOCK1) && (retry_cnt != '0));

    assert_fail_parked_R8: assert property (@(posedge clk) disable iff (rst)
        fail |-> (phase_q == PH_OFF));

    assert_leave_off_R9: assert property (@(posedge clk) disable iff (rst)
        !train_en |=> (phase_q == PH_OFF));

endmodule

// File: tb/ltrain_seq_bench.sv
module ltrain_seq_bench;

    localparam int TXM = 4;
    localparam int RXM = 2;
    localparam int TMO = 20;
    localparam int MR  = 2;

    logic       clk = 1'b0;
    logic       rst;
    logic       train_en, rx_valid, tx_done, tx_abort;
    logic [2:0] rx_set;
    logic [2:0] tx_set, phase;
    logic       trained, retry_pulse, fail;
    logic [1:0] retry_cnt;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ltrain_seq #(.TX_MIN(TXM), .RX_MIN(RXM), .TIMEOUT(TMO), .MAX_RETRY(MR)) u_ltrain_seq (
        .clk(clk), .rst(rst), .train_en(train_en), .rx_valid(rx_valid),
        .rx_set(rx_set), .tx_done(tx_done), .tx_abort(tx_abort),
        .tx_set(tx_set), .phase(phase), .trained(trained),
        .retry_pulse(retry_pulse), .retry_cnt(retry_cnt), .fail(fail)
    );

    // {en, rx_valid, rx_set[2:0], tx_done, tx_abort, expected phase[2:0]}
    localparam logic [9:0] VEC [17] = '{
        {1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 3'd1},   // R9 enter LOCK1
        {1'b1, 1'b1, 3'd1, 1'b0, 1'b0, 3'd1},   // R1 receive first
        {1'b1, 1'b1, 3'd1, 1'b0, 1'b0, 3'd1},   // R1 rx met, tx not
        {1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 3'd1},
        {1'b1, 1'b0, 3'd0, 1'b1, 1'b1, 3'd1},   // R3 interrupted set
        {1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 3'd1},
        {1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 3'd1},
        {1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 3'd1},   // R3 only three counted
        {1'b1, 1'b1, 3'd2, 1'b0, 1'b0, 3'd1},   // R2 foreign type
        {1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 3'd1},
        {1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 3'd1},   // R1 tx met alone
        {1'b1, 1'b1, 3'd1, 1'b0, 1'b0, 3'd1},
        {1'b1, 1'b1, 3'd3, 1'b0, 1'b0, 3'd1},   // R2 break
        {1'b1, 1'b1, 3'd1, 1'b0, 1'b0, 3'd1},
        {1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 3'd1},   // R2 idle gap
        {1'b1, 1'b1, 3'd1, 1'b0, 1'b0, 3'd1},
        {1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 3'd2}    // R5 advance next edge
    };

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        rx_valid = 1'b0; rx_set = 3'd0; tx_done = 1'b0; tx_abort = 1'b0;
    endtask

    // four matched cycles, then the advance cycle carrying a stray strobe
    task automatic run_phase(int cur);
        check("R4 set for phase", tx_set, cur);
        for (int k = 0; k < 4; k++) begin
            rx_valid = 1'b1; rx_set = 3'(cur); tx_done = 1'b1;
            step();
        end
        check("R5 no advance before next edge", phase, cur);
        rx_valid = 1'b0; tx_done = 1'b1;   // R6 dropped strobe
        step();
        idle_inputs();
        check("R5 advance", phase, cur + 1);
    endtask

    initial begin
        rst = 1'b1; train_en = 1'b0;
        idle_inputs();
        step(); step();
        check("R10 phase", phase, 0);
        check("R10 tx_set", tx_set, 0);
        check("R10 trained", trained, 0);
        check("R10 retry_cnt", retry_cnt, 0);
        check("R10 fail", fail, 0);
        rst = 1'b0;

        for (int i = 0; i < 17; i++) begin
            train_en = VEC[i][9]; rx_valid = VEC[i][8]; rx_set = VEC[i][7:5];
            tx_done  = VEC[i][4]; tx_abort = VEC[i][3];
            step();
            check($sformatf("R1 R2 R3 R5 table row %0d", i), phase, int'(VEC[i][2:0]));
        end
        idle_inputs();

        run_phase(2);
        run_phase(3);
        run_phase(4);
        check("R5 trained", trained, 1);
        check("R5 done sends none", tx_set, 0);
        step(); step();
        check("R5 done holds", phase, 5);

        train_en = 1'b0; step();
        check("R9 leave to off", phase, 0);
        check("R9 trained cleared", trained, 0);
        train_en = 1'b1; step();
        check("R9 re-enter LOCK1", phase, 1);
        check("R4 LOCK1 set", tx_set, 1);

        // window 1: receive only
        for (int k = 1; k <= TMO; k++) begin
            rx_valid = 1'b1; rx_set = 3'd1;
            step();
            if (k == TMO - 1) begin
                check("R1 rx alone holds", phase, 1);
                check("R7 no early retry", retry_cnt, 0);
            end
        end
        idle_inputs();
        check("R7 retry count", retry_cnt, 1);
        check("R7 retry pulse", retry_pulse, 1);
        check("R7 back in LOCK1", phase, 1);

        // window 2: send only; stale receive run must be gone
        for (int k = 1; k <= TMO; k++) begin
            tx_done = 1'b1;
            step();
            if (k == 1) check("R7 pulse one cycle", retry_pulse, 0);
            if (k == TMO - 1) check("R6 counts cleared on restart", phase, 1);
        end
        idle_inputs();
        check("R7 second retry", retry_cnt, 2);

        // window 3: exhausted
        for (int k = 1; k <= TMO; k++) step();
        check("R8 fail set", fail, 1);
        check("R8 parked off", phase, 0);
        check("R8 no pulse on fail", retry_pulse, 0);
        for (int k = 0; k < 5; k++) step();
        check("R8 stays off", phase, 0);
        check("R8 sticky", fail, 1);

        rst = 1'b1; step();
        rst = 1'b0; train_en = 1'b0;
        check("R10 fail cleared", fail, 0);
        check("R10 retries cleared", retry_cnt, 0);
        check("R10 phase off", phase, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule